// File: doc/BRIEF.md
# Double-Operand Funnel Shifter

This block is the double-width shift stage of an integer datapath. A primary operand is shifted left or right. The bit positions it vacates are filled from a second operand, which is held in a small local register. The operation works on 1, 2, 4 or 8 bytes. The result is written back into the low part of the old destination value, and bits above the operand size keep their old values. Alongside the result, the block produces new carry, extended-carry and overflow flags. A per-flag enable mask selects which of these flags may change.

The shift itself is purely combinational. Operations stream through a valid/ready pair that adds no storage. A result is offered in the same cycle its operation is presented. An operation is consumed in the cycle where `op_valid` and `res_ready` are both high. Back-pressure from `res_ready` reaches `op_ready` unchanged and in the same cycle. While `op_ready` is low, the producer must hold the operation. The fill register is loaded through a plain write port at a clock edge, and an operation always sees the value the register held before that edge.

Top module: `dbl_funnel_shifter`

## Requirements
- R1: The raw count is reduced to its low 6 bits when `op_size` is 3 (8 bytes) and to its low 5 bits for `op_size` 0, 1 and 2 (1, 2 and 4 bytes). With w = 8·2^op_size bits, the effective count n is the reduced count modulo 2w.
- R2: For a left shift (`op_dir` = 0) with 0 < n < w, the result is (P << n) | (S >> (w−n)). For w ≤ n < 2w it is (S << (n−w)) | (P >> (2w−n)). P is the primary operand and S is the fill register, both taken to w bits, and the result is truncated to w bits.
- R3: For a right shift (`op_dir` = 1) with 0 < n < w, the result is (P >> n) | (S << (w−n)). For w ≤ n < 2w it is (S >> (n−w)) | (P << (2w−n)). Vacated positions are zero-filled before the OR.
- R4: When n is 0, the low w result bits equal P.
- R5: `res_dest` bits at and above w equal the same bits of `op_dest_old`, and bits below w carry the result.
- R6: When the reduced count is 0, `res_flags` equals `op_flags_in`.
- R7: With a nonzero reduced count, let m = n, or m = 2w when n is 0. For a left shift, the carry is P[w−m] when m ≤ w and S[2w−m] otherwise. For a right shift, it is P[m−1] when m ≤ w and S[m−w−1] otherwise. The carry is written to every enabled flag among carry (bit 0) and extended carry (bit 1).
- R8: With a nonzero reduced count, overflow (bit 2) is P[w−1] XOR result[w−1] when enabled.
- R9: A flag whose `op_flag_en` bit is 0 keeps its `op_flags_in` value.
- R10: The fill register resets to 0 and loads `dbl_wr_a ^ dbl_wr_b` at a rising edge when `dbl_wr_en` is 1; otherwise it holds. An operation in the same cycle as a write uses the old value.
- R11: `res_valid` equals `op_valid` and `op_ready` equals `res_ready` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbl_wr_en | input | 1 | Fill register write strobe |
| dbl_wr_a | input | 64 | Fill register write term A |
| dbl_wr_b | input | 64 | Fill register write term B (XORed with A) |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation accepted when high with op_valid |
| op_dir | input | 1 | 0 = left, 1 = right |
| op_size | input | 2 | 0/1/2/3 = 1/2/4/8 bytes |
| op_count | input | CNT_W | Raw shift count |
| op_src | input | 64 | Primary operand |
| op_dest_old | input | 64 | Previous destination value |
| op_flag_en | input | 3 | Enables: bit0 carry, bit1 extended carry, bit2 overflow |
| op_flags_in | input | 3 | Incoming flags, same bit order |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer can take the result |
| res_dest | output | 64 | Merged destination value |
| res_flags | output | 3 | Updated flags |

## Verification
A fill register write and a shift can fall in the same cycle. The bench holds an operation steady while it strobes a new fill value. It reads the result just before the edge and expects the old fill bits. It reads again just after the edge and expects the new ones. A second overlap comes from a reduced count of zero while the enables are set. The bench reaches this through counts such as 32 at one byte or 64 at eight bytes, and judges it by flags that do not move while the result still follows the wrapped count.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned NEXT_W = $clog2(2 * XLEN) + 1;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } opsize_e;

  typedef struct packed {
    logic of;
    logic ecf;
    logic cf;
  } shflags_t;
endpackage

// File: rtl/fsh_count_norm.sv
module fsh_count_norm
  import fsh_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  opsize_e            size,
  input  logic [CNT_W-1:0]   count,
  output logic               masked_zero,
  output logic [NEXT_W-1:0]  n_ext
);
  logic [5:0] masked;
  logic [7:0] two_w;
  logic [6:0] eff;
  logic       unused_hi;

  assign unused_hi = ^count[CNT_W-1:6];

  always_comb begin
    masked = (size == SZ_B8) ? count[5:0] : {1'b0, count[4:0]};
    unique case (size)
      SZ_B1:   two_w = 8'd16;
      SZ_B2:   two_w = 8'd32;
      SZ_B4:   two_w = 8'd64;
      default: two_w = 8'd128;
    endcase
    eff         = {1'b0, masked} & 7'(two_w - 8'd1);
    masked_zero = (masked == 6'd0);
    n_ext       = (eff == 7'd0) ? NEXT_W'(two_w) : NEXT_W'(eff);
  end
endmodule

// File: rtl/fsh_funnel_core.sv
module fsh_funnel_core
  import fsh_pkg::*;
(
  input  logic              dir,
  input  opsize_e           size,
  input  logic [NEXT_W-1:0] n_ext,
  input  logic [XLEN-1:0]   prim,
  input  logic [XLEN-1:0]   sec,
  output logic [XLEN-1:0]   res,
  output logic              carry,
  output logic              ovf
);
  logic [XLEN-1:0] res_all [4];
  logic            cy_all  [4];
  logic            of_all  [4];

  for (genvar g = 0; g < 4; g++) begin : g_size
    localparam int W  = 8 << g;
    localparam int LW = $clog2(2 * W);
    logic [LW:0]    nl, shl;
    logic [2*W-1:0] cl, cr;
    logic [W-1:0]   rl, rr, rsel;
    logic           cyl, cyr;

    assign nl   = n_ext[LW:0];
    assign shl  = (LW+1)'(2 * W) - nl;
    assign cl   = {prim[W-1:0], sec[W-1:0]};
    assign cr   = {sec[W-1:0], prim[W-1:0]};
    assign rl   = W'(((cl << nl) | (cl >> shl)) >> W);
    assign rr   = W'((cr >> nl) | (cr << shl));
    assign cyl  = cl[shl[LW-1:0]];
    assign cyr  = cr[LW'(nl - 1'b1)];
    assign rsel = dir ? rr : rl;

    assign res_all[g] = XLEN'(rsel);
    assign cy_all[g]  = dir ? cyr : cyl;
    assign of_all[g]  = prim[W-1] ^ rsel[W-1];
  end

  assign res   = res_all[size];
  assign carry = cy_all[size];
  assign ovf   = of_all[size];
endmodule

// File: rtl/fsh_flag_merge.sv
module fsh_flag_merge
  import fsh_pkg::*;
(
  input  logic     masked_zero,
  input  shflags_t en,
  input  shflags_t flags_in,
  input  logic     carry,
  input  logic     ovf,
  output shflags_t flags_out
);
  always_comb begin
    flags_out = flags_in;
    if (!masked_zero) begin
      if (en.cf)  flags_out.cf  = carry;
      if (en.ecf) flags_out.ecf = carry;
      if (en.of)  flags_out.of  = ovf;
    end
  end
endmodule

// File: rtl/fsh_dbl_reg.sv
module fsh_dbl_reg
  import fsh_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wa,
  input  logic [XLEN-1:0] wb,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wa ^ wb;
  end
endmodule

// File: rtl/dbl_funnel_shifter.sv
module dbl_funnel_shifter
  import fsh_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbl_wr_en,
  input  logic [63:0]      dbl_wr_a,
  input  logic [63:0]      dbl_wr_b,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic             op_dir,
  input  logic [1:0]       op_size,
  input  logic [CNT_W-1:0] op_count,
  input  logic [63:0]      op_src,
  input  logic [63:0]      op_dest_old,
  input  logic [2:0]       op_flag_en,
  input  logic [2:0]       op_flags_in,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [63:0]      res_dest,
  output logic [2:0]       res_flags
);
  opsize_e           size_q;
  logic [XLEN-1:0]   dbl_q;
  logic              masked_zero;
  logic [NEXT_W-1:0] n_ext;
  logic [XLEN-1:0]   core_res;
  logic              carry, ovf;
  logic [XLEN-1:0]   low_mask;
  shflags_t          flags_out;

  assign size_q = opsize_e'(op_size);

  fsh_dbl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(dbl_wr_en),
    .wa(dbl_wr_a), .wb(dbl_wr_b), .q(dbl_q)
  );

  fsh_count_norm #(.CNT_W(CNT_W)) u_norm (
    .size(size_q), .count(op_count),
    .masked_zero(masked_zero), .n_ext(n_ext)
  );

  fsh_funnel_core u_core (
    .dir(op_dir), .size(size_q), .n_ext(n_ext),
    .prim(op_src), .sec(dbl_q),
    .res(core_res), .carry(carry), .ovf(ovf)
  );

  fsh_flag_merge u_flags (
    .masked_zero(masked_zero), .en(shflags_t'(op_flag_en)),
    .flags_in(shflags_t'(op_flags_in)),
    .carry(carry), .ovf(ovf), .flags_out(flags_out)
  );

  always_comb begin
    unique case (size_q)
      SZ_B1:   low_mask = 64'h0000_0000_0000_00FF;
      SZ_B2:   low_mask = 64'h0000_0000_0000_FFFF;
      SZ_B4:   low_mask = 64'h0000_0000_FFFF_FFFF;
      default: low_mask = '1;
    endcase
  end

  assign res_dest  = (core_res & low_mask) | (op_dest_old & ~low_mask);
  assign res_flags = flags_out;
  assign res_valid = op_valid;
  assign op_ready  = res_ready;
endmodule

// File: rtl/fsh_checker.sv
module fsh_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dbl_wr_en,
  input logic [63:0]      dbl_wr_a,
  input logic [63:0]      dbl_wr_b,
  input logic [63:0]      dbl_q,
  input logic             op_valid,
  input logic             op_ready,
  input logic [1:0]       op_size,
  input logic [CNT_W-1:0] op_count,
  input logic [63:0]      op_src,
  input logic [63:0]      op_dest_old,
  input logic [2:0]       op_flag_en,
  input logic [2:0]       op_flags_in,
  input logic             res_valid,
  input logic             res_ready,
  input logic [63:0]      res_dest,
  input logic [2:0]       res_flags
);
  logic        cnt_zero;
  logic [63:0] keep_mask;

  assign cnt_zero  = (op_size == 2'd3) ? (op_count[5:0] == 6'd0)
                                       : (op_count[4:0] == 5'd0);
  assign keep_mask = (op_size == 2'd0) ? ~64'hFF :
                     (op_size == 2'd1) ? ~64'hFFFF :
                     (op_size == 2'd2) ? ~64'hFFFF_FFFF : 64'h0;

  assert_handshake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid == op_valid) && (op_ready == res_ready));

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cnt_zero) |-> (res_flags == op_flags_in));

  assert_upper_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> ((res_dest & keep_mask) == (op_dest_old & keep_mask)));

  assert_flag_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (((res_flags ^ op_flags_in) & ~op_flag_en) == 3'b000));

  assert_zero_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_size == 2'd3 && cnt_zero) |-> (res_dest == op_src));

  assert_reg_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_wr_en |=> (dbl_q == $past(dbl_wr_a ^ dbl_wr_b)));

  assert_reg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl_wr_en |=> $stable(dbl_q));
endmodule

bind dbl_funnel_shifter fsh_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbl_wr_en(dbl_wr_en), .dbl_wr_a(dbl_wr_a),
  .dbl_wr_b(dbl_wr_b), .dbl_q(dbl_q), .op_valid(op_valid),
  .op_ready(op_ready), .op_size(op_size), .op_count(op_count),
  .op_src(op_src), .op_dest_old(op_dest_old), .op_flag_en(op_flag_en),
  .op_flags_in(op_flags_in), .res_valid(res_valid), .res_ready(res_ready),
  .res_dest(res_dest), .res_flags(res_flags)
);

// File: tb/dbl_funnel_shifter_tb.sv
`timescale 1ns/1ps
module dbl_funnel_shifter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbl_wr_en = 1'b0;
  logic [63:0] dbl_wr_a = '0, dbl_wr_b = '0;
  logic        op_valid = 1'b0, op_ready;
  logic        op_dir = 1'b0;
  logic [1:0]  op_size = 2'd0;
  logic [7:0]  op_count = '0;
  logic [63:0] op_src = '0, op_dest_old = '0;
  logic [2:0]  op_flag_en = '0, op_flags_in = '0;
  logic        res_valid, res_ready = 1'b0;
  logic [63:0] res_dest;
  logic [2:0]  res_flags;

  int          n_vec = 0, n_bad = 0;
  logic [63:0] s_model = '0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dbl_funnel_shifter u_dut (.*);

  function automatic void model(input logic dir, input logic [1:0] sz,
      input logic [7:0] cnt, input logic [63:0] p_in, input logic [63:0] s_in,
      input logic [63:0] dold, input logic [2:0] fen, input logic [2:0] fin,
      output logic [63:0] dst, output logic [2:0] fl);
    int w, mk, n, m;
    logic [63:0] msk, p, s, r;
    logic cy, ov;
    w   = 8 << sz;
    mk  = (sz == 2'd3) ? int'(cnt & 8'h3F) : int'(cnt & 8'h1F);
    n   = mk % (2 * w);
    msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    p   = p_in & msk;
    s   = s_in & msk;
    if (n == 0)      r = p;
    else if (!dir)   r = (n < w) ? ((p << n) | (s >> (w - n)))
                                 : ((s << (n - w)) | (p >> (2 * w - n)));
    else             r = (n < w) ? ((p >> n) | (s << (w - n)))
                                 : ((s >> (n - w)) | (p << (2 * w - n)));
    r   = r & msk;
    dst = (dold & ~msk) | r;
    fl  = fin;
    if (mk != 0) begin
      m = (n == 0) ? 2 * w : n;
      if (!dir) cy = (m <= w) ? p[w - m] : s[2 * w - m];
      else      cy = (m <= w) ? p[m - 1] : s[m - w - 1];
      ov = p[w - 1] ^ r[w - 1];
      if (fen[0]) fl[0] = cy;
      if (fen[1]) fl[1] = cy;
      if (fen[2]) fl[2] = ov;
    end
  endfunction

  task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_fill(input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    dbl_wr_en = 1'b1; dbl_wr_a = a; dbl_wr_b = b;
    @(negedge clk);
    dbl_wr_en = 1'b0;
    s_model = a ^ b;
  endtask

  task automatic run_op(input string tag, input logic dir, input logic [1:0] sz,
                        input logic [7:0] cnt);
    logic [63:0] ed;
    logic [2:0]  ef;
    op_valid = 1'b1; res_ready = 1'b1;
    op_dir = dir; op_size = sz; op_count = cnt;
    op_src = {$urandom, $urandom}; op_dest_old = {$urandom, $urandom};
    op_flag_en = 3'($urandom); op_flags_in = 3'($urandom);
    #1;
    model(dir, sz, cnt, op_src, s_model, op_dest_old, op_flag_en, op_flags_in, ed, ef);
    chk64({tag, " result"}, res_dest, ed);
    chk64({tag, " flags"}, 64'(res_flags), 64'(ef));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ed, ed2;
    logic [2:0]  ef;
    logic [63:0] old_s, new_s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: register resets to zero; left shift by w at one byte returns S
    op_valid = 1'b1; res_ready = 1'b1; op_dir = 1'b0; op_size = 2'd0;
    op_count = 8'd8; op_src = 64'hFF; op_dest_old = 64'h1234_5678_9ABC_DE00;
    op_flag_en = 3'b000; op_flags_in = 3'b101;
    #1 chk64("R10 reset fill", res_dest, 64'h1234_5678_9ABC_DE00);

    // R2 R3 R4 R6 R7 R8 R9: every size, direction and count 0..63
    for (int sz = 0; sz < 4; sz++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 64; c++) begin
          if (c % 4 == 0) write_fill({$urandom, $urandom}, {$urandom, $urandom});
          @(negedge clk);
          run_op(d ? "R3/R4/R6/R7/R8/R9" : "R2/R4/R6/R7/R8/R9",
                 d[0], sz[1:0], 8'(c));
        end

    // R1: raw counts above 63 lose their high bits
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      run_op("R1 count reduce", 1'($urandom), 2'($urandom), 8'($urandom | 32'h40));
    end

    // R5: upper bits survive for sizes below 8 bytes
    for (int sz = 0; sz < 3; sz++) begin
      @(negedge clk);
      run_op("R5", 1'b1, sz[1:0], 8'd5);
      ed = ~((64'd1 << (8 << sz)) - 64'd1);
      chk64("R5 upper keep", res_dest & ed, op_dest_old & ed);
    end

    // R6 directed: 8-byte count 64 reduces to zero, flags pinned
    @(negedge clk);
    op_size = 2'd3; op_count = 8'd64; op_flag_en = 3'b111; op_flags_in = 3'b010;
    op_src = 64'hDEAD_BEEF_0000_0001;
    #1;
    chk64("R6 flags", 64'(res_flags), 64'h2);
    chk64("R4 pass", res_dest, 64'hDEAD_BEEF_0000_0001);

    // R7 directed: one byte, count 16 wraps to 0, left carry is S[0]
    write_fill(64'h0, 64'h01);
    op_dir = 1'b0; op_size = 2'd0; op_count = 8'd16; op_flag_en = 3'b011;
    op_flags_in = 3'b000; op_src = 64'h00; op_dest_old = '0;
    #1 chk64("R7 wrap carry", 64'(res_flags), 64'h3);

    // R11: handshake pass-through under random patterns
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      op_valid = 1'($urandom); res_ready = 1'($urandom);
      #1;
      chk64("R11 valid", 64'(res_valid), 64'(op_valid));
      chk64("R11 ready", 64'(op_ready), 64'(res_ready));
    end

    // R10: write and shift in the same cycle
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      old_s = s_model;
      new_s = {$urandom, $urandom};
      op_valid = 1'b1; res_ready = 1'b1; op_dir = 1'($urandom);
      op_size = 2'($urandom); op_count = 8'($urandom);
      op_src = {$urandom, $urandom}; op_dest_old = {$urandom, $urandom};
      op_flag_en = 3'b111; op_flags_in = 3'($urandom);
      dbl_wr_en = 1'b1; dbl_wr_a = new_s; dbl_wr_b = 64'h0;
      #1;
      model(op_dir, op_size, op_count, op_src, old_s, op_dest_old, op_flag_en,
            op_flags_in, ed, ef);
      chk64("R10 old fill same cycle", res_dest, ed);
      @(posedge clk); #1;
      dbl_wr_en = 1'b0;
      s_model = new_s;
      model(op_dir, op_size, op_count, op_src, new_s, op_dest_old, op_flag_en,
            op_flags_in, ed2, ef);
      chk64("R10 new fill after edge", res_dest, ed2);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule